// File: doc/BRIEF.md
# DMA Descriptor Chain Walker

This block runs a linked list of DMA transfers without a processor stepping in between them. Software or back-end logic writes a start pointer and pulses a start strobe. The walker then reads a 32-byte descriptor from memory as four 64-bit words over a simple one-outstanding read port. It hands the decoded transfer to a separate transfer engine as a held command, and waits for that engine's done pulse. It then follows the pointer stored in the descriptor to the next record. The walk ends after a transfer whose descriptor carries the end-of-chain flag.

Each descriptor is laid out as four words. Word 0 is the bus address of the transfer. Word 1 is 64 free-form user bits, for example a local address. Word 2 holds the byte count in bits [63:32], 24 more user bits in [31:8] and a control byte in [7:0]. Word 3 is the address of the next descriptor. The 88 user bits travel with each command, so the back-end can tell transfers apart. A cancel request stops the walk at the next descriptor boundary without cutting a transfer or a read that is already in progress.

Top module: `dma_chain_walker`

## Requirements
- R1: After reset, rd_req_o, xfer_valid_o, busy_o, chain_done_o and irq_o are all low.
- R2: A start_i pulse while idle begins a walk at chain_addr_i with its low 5 bits cleared. Each descriptor is read as four quad-words at base, base+8, base+16 and base+24, in that order.
- R3: Once raised, rd_req_o stays high with rd_addr_o unchanged until the cycle in which rd_valid_i is seen. Only one read is outstanding at a time.
- R4: A transfer command is presented only after all four words are captured. xfer_addr_o is word 0, xfer_bytes_o is word 2 bits [63:32], and xfer_write_o is word 2 bit 0 (1 = write). xfer_valid_o and all command fields hold until xfer_done_i.
- R5: xfer_tag_o is {word 1, word 2 bits [31:8]}, 88 bits.
- R6: The next descriptor is read only after xfer_done_i for the current one. Its base is word 3 with the low 5 bits cleared. No read is requested while a command is valid.
- R7: When a transfer whose word 2 bit 1 (end-of-chain) is set completes, busy_o falls and chain_done_o rises. chain_done_o stays high until the next accepted start.
- R8: irq_o pulses for exactly one cycle at chain completion when the last descriptor has word 2 bit 2 set. It stays low when that bit is clear.
- R9: cancel_i while busy ends the walk at the next boundary. A transfer or read in progress completes, no further command is issued, busy_o falls, and chain_done_o stays low.
- R10: If cancel arrives in the same cycle as the done of an end-of-chain transfer, the chain counts as completed and chain_done_o rises.
- R11: start_i while busy has no effect on the walk. cancel_i while idle has no effect on the next walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Begin a walk (accepted when idle) |
| chain_addr_i | input | 64 | Address of the first descriptor |
| cancel_i | input | 1 | Stop the walk at the next boundary |
| rd_req_o | output | 1 | Memory read request |
| rd_addr_o | output | 64 | Quad-word address of the read |
| rd_valid_i | input | 1 | Read data returned this cycle |
| rd_data_i | input | 64 | Read data |
| xfer_valid_o | output | 1 | Transfer command present |
| xfer_addr_o | output | 64 | Transfer bus address |
| xfer_bytes_o | output | 32 | Transfer byte count |
| xfer_write_o | output | 1 | Direction, 1 = write |
| xfer_tag_o | output | 88 | User-defined descriptor bits |
| xfer_done_i | input | 1 | Transfer engine finished the command |
| busy_o | output | 1 | Walk in progress |
| chain_done_o | output | 1 | Last walk reached its end-of-chain descriptor |
| irq_o | output | 1 | One-cycle completion interrupt |

## Verification
Two events can land in the same cycle: a cancel request and the done of a transfer whose descriptor ends the chain. The bench provokes this by having its transfer-engine model raise cancel_i in the very cycle it raises xfer_done_i on a single last descriptor. It then judges the outcome: exactly one command was issued, busy falls, and chain_done_o is set, not suppressed. A start strobe landing while a command is held is also covered, and must leave the read and command counts untouched.

// File: rtl/chain_walk_pkg.sv
// chain_walk_pkg
// Shared constants and types of the descriptor chain walker.
// Assumes the fixed four-quad-word descriptor layout described in the brief.
package chain_walk_pkg;
    localparam int QW_W       = 64;               // width of one descriptor word
    localparam int DESC_QW    = 4;                // words per descriptor
    localparam int QW_IDX_W   = $clog2(DESC_QW);
    localparam int DESC_ALIGN = $clog2(DESC_QW * QW_W / 8); // 32-byte records
    localparam int CNT_W      = 32;
    localparam int CNT_LSB    = 32;               // byte count in word 2 [63:32]
    localparam int USR2_W     = 24;
    localparam int USR2_LSB   = 8;                // extra user bits in word 2 [31:8]
    localparam int TAG_W      = QW_W + USR2_W;
    localparam int FLG_WRITE  = 0;                // control byte bit positions
    localparam int FLG_LAST   = 1;
    localparam int FLG_IRQ    = 2;

    typedef enum logic [1:0] {
        WALK_IDLE  = 2'd0,
        WALK_FETCH = 2'd1,
        WALK_XFER  = 2'd2
    } walk_state_e;
endpackage

// File: rtl/chain_fetch.sv
// chain_fetch
// Reads one descriptor of NQW words, starting at a loaded base pointer.
// Keeps a single read outstanding: the request is held with a fixed address
// until the data strobe is seen. Captured words stay stable until the next load.
// Assumes the loader never loads while a fetch is active.
module chain_fetch #(
    parameter int AW  = 64,
    parameter int DW  = 64,
    parameter int NQW = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [AW-1:0]     ptr_i,
    input  logic              rvalid_i,
    input  logic [DW-1:0]     rdata_i,
    output logic              req_o,
    output logic [AW-1:0]     addr_o,
    output logic              done_o,
    output logic [NQW*DW-1:0] words_o
);
    localparam int IW       = $clog2(NQW);
    localparam int STEP_LOG = $clog2(DW / 8);

    logic          active;
    logic [IW-1:0] idx;
    logic [AW-1:0] base;
    logic          take;

    assign take   = active && rvalid_i;
    assign req_o  = active;
    assign addr_o = base + (AW'(idx) << STEP_LOG);

    // Word sequencing: start on load, step on each returned word, flag the end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            idx    <= '0;
            base   <= '0;
            done_o <= 1'b0;
        end else begin
            done_o <= 1'b0;
            if (load_i) begin
                active <= 1'b1;
                idx    <= '0;
                base   <= ptr_i;
            end else if (take) begin
                idx <= idx + 1'b1;
                if (idx == IW'(NQW - 1)) begin
                    active <= 1'b0;
                    done_o <= 1'b1;
                end
            end
        end
    end

    // One capture register per descriptor word.
    for (genvar g = 0; g < NQW; g++) begin : g_word
        always_ff @(posedge clk) begin
            if (!rst_n)
                words_o[g*DW +: DW] <= '0;
            else if (take && idx == IW'(g))
                words_o[g*DW +: DW] <= rdata_i;
        end
    end
endmodule

// File: rtl/chain_ctrl.sv
// chain_ctrl
// Walk sequencer: idle, fetching a descriptor, or holding a transfer command.
// Decides at each boundary whether to continue, finish or stop on cancel.
// Assumes descriptor fields are stable while in the transfer state.
module chain_ctrl
    import chain_walk_pkg::*;
#(
    parameter int AW        = 64,
    parameter int ALIGN_LOG = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [AW-1:0] start_addr_i,
    input  logic          cancel_i,
    input  logic          fetch_done_i,
    input  logic [AW-1:0] next_ptr_i,
    input  logic          last_i,
    input  logic          irq_en_i,
    input  logic          xfer_done_i,
    output logic          fetch_load_o,
    output logic [AW-1:0] fetch_ptr_o,
    output logic          busy_o,
    output logic          cmd_valid_o,
    output logic          chain_done_o,
    output logic          irq_o
);
    localparam logic [AW-1:0] ALIGN_MASK = ~((AW'(1) << ALIGN_LOG) - AW'(1));

    walk_state_e state, state_nxt;
    logic        cancel_pend;
    logic        cancel_now;
    logic        start_ok;
    logic        xfer_end;
    logic        go_next;

    assign cancel_now   = cancel_pend || cancel_i;
    assign start_ok     = (state == WALK_IDLE) && start_i;
    assign xfer_end     = (state == WALK_XFER) && xfer_done_i;
    assign go_next      = xfer_end && !last_i && !cancel_now;
    assign fetch_load_o = start_ok || go_next;
    assign fetch_ptr_o  = (start_ok ? start_addr_i : next_ptr_i) & ALIGN_MASK;
    assign busy_o       = (state != WALK_IDLE);
    assign cmd_valid_o  = (state == WALK_XFER);

    // Next-state choice at each boundary.
    always_comb begin
        state_nxt = state;
        unique case (state)
            WALK_IDLE:  if (start_i) state_nxt = WALK_FETCH;
            WALK_FETCH: if (fetch_done_i) state_nxt = cancel_now ? WALK_IDLE : WALK_XFER;
            WALK_XFER:  if (xfer_done_i) state_nxt = go_next ? WALK_FETCH : WALK_IDLE;
            default:    state_nxt = WALK_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= WALK_IDLE;
        else        state <= state_nxt;
    end

    // Pending cancel: held while busy, dropped whenever the walk returns to idle.
    always_ff @(posedge clk) begin
        if (!rst_n) cancel_pend <= 1'b0;
        else        cancel_pend <= (state != WALK_IDLE) && (state_nxt != WALK_IDLE) && cancel_now;
    end

    // Completion status and interrupt pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_done_o <= 1'b0;
            irq_o        <= 1'b0;
        end else begin
            irq_o <= xfer_end && last_i && irq_en_i;
            if (start_ok)
                chain_done_o <= 1'b0;
            else if (xfer_end && last_i)
                chain_done_o <= 1'b1;
        end
    end
endmodule

// File: rtl/dma_chain_walker.sv
// dma_chain_walker
// Top of the descriptor chain walker: joins the word fetcher to the sequencer
// and slices the captured descriptor into the transfer command fields.
// Assumes 64-bit descriptor words in the fixed layout of chain_walk_pkg.
module dma_chain_walker
    import chain_walk_pkg::*;
#(
    parameter int ADDR_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] chain_addr_i,
    input  logic              cancel_i,
    output logic              rd_req_o,
    output logic [ADDR_W-1:0] rd_addr_o,
    input  logic              rd_valid_i,
    input  logic [QW_W-1:0]   rd_data_i,
    output logic              xfer_valid_o,
    output logic [QW_W-1:0]   xfer_addr_o,
    output logic [CNT_W-1:0]  xfer_bytes_o,
    output logic              xfer_write_o,
    output logic [TAG_W-1:0]  xfer_tag_o,
    input  logic              xfer_done_i,
    output logic              busy_o,
    output logic              chain_done_o,
    output logic              irq_o
);
    logic                    f_load;
    logic [ADDR_W-1:0]       f_ptr;
    logic                    f_done;
    logic [DESC_QW*QW_W-1:0] words;
    logic [QW_W-1:0]         w_addr, w_user, w_ctl, w_next;

    assign w_addr = words[0*QW_W +: QW_W];
    assign w_user = words[1*QW_W +: QW_W];
    assign w_ctl  = words[2*QW_W +: QW_W];
    assign w_next = words[3*QW_W +: QW_W];

    assign xfer_addr_o  = w_addr;
    assign xfer_bytes_o = w_ctl[CNT_LSB +: CNT_W];
    assign xfer_write_o = w_ctl[FLG_WRITE];
    assign xfer_tag_o   = {w_user, w_ctl[USR2_LSB +: USR2_W]};

    chain_fetch #(.AW(ADDR_W), .DW(QW_W), .NQW(DESC_QW)) u_fetch (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (f_load),
        .ptr_i    (f_ptr),
        .rvalid_i (rd_valid_i),
        .rdata_i  (rd_data_i),
        .req_o    (rd_req_o),
        .addr_o   (rd_addr_o),
        .done_o   (f_done),
        .words_o  (words)
    );

    chain_ctrl #(.AW(ADDR_W), .ALIGN_LOG(DESC_ALIGN)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .start_addr_i (chain_addr_i),
        .cancel_i     (cancel_i),
        .fetch_done_i (f_done),
        .next_ptr_i   (w_next[ADDR_W-1:0]),
        .last_i       (w_ctl[FLG_LAST]),
        .irq_en_i     (w_ctl[FLG_IRQ]),
        .xfer_done_i  (xfer_done_i),
        .fetch_load_o (f_load),
        .fetch_ptr_o  (f_ptr),
        .busy_o       (busy_o),
        .cmd_valid_o  (xfer_valid_o),
        .chain_done_o (chain_done_o),
        .irq_o        (irq_o)
    );
endmodule

// File: rtl/chain_walk_checker.sv
// chain_walk_checker
// Port-level properties of the chain walker, attached by bind.
module chain_walk_checker #(
    parameter int AW = 64
) (
    input logic          clk,
    input logic          rst_n,
    input logic          rd_req,
    input logic [AW-1:0] rd_addr,
    input logic          rd_valid,
    input logic          xfer_valid,
    input logic [63:0]   xfer_addr,
    input logic [31:0]   xfer_bytes,
    input logic [87:0]   xfer_tag,
    input logic          xfer_done,
    input logic          busy,
    input logic          chain_done,
    input logic          irq
);
    assert_rd_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req && !rd_valid |=> rd_req && $stable(rd_addr));

    assert_rd_align_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> rd_addr[2:0] == 3'b000);

    assert_cmd_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_valid && !xfer_done |=> xfer_valid && $stable(xfer_addr)
                                   && $stable(xfer_bytes) && $stable(xfer_tag));

    assert_no_overlap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_req && xfer_valid));

    assert_irq_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        chain_done |-> !busy);

    assert_irq_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> chain_done);
endmodule

bind dma_chain_walker chain_walk_checker #(.AW(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_req     (rd_req_o),
    .rd_addr    (rd_addr_o),
    .rd_valid   (rd_valid_i),
    .xfer_valid (xfer_valid_o),
    .xfer_addr  (xfer_addr_o),
    .xfer_bytes (xfer_bytes_o),
    .xfer_tag   (xfer_tag_o),
    .xfer_done  (xfer_done_i),
    .busy       (busy_o),
    .chain_done (chain_done_o),
    .irq        (irq_o)
);

// File: tb/dma_chain_walker_bench.sv
// Directed bench for the chain walker: memory and transfer-engine models,
// one task per scenario.
module dma_chain_walker_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [63:0] chain_addr = '0;
    logic        cancel_i = 1'b0;
    logic        rd_req;
    logic [63:0] rd_addr;
    logic        rd_valid = 1'b0;
    logic [63:0] rd_data = '0;
    logic        xfer_valid;
    logic [63:0] xfer_addr;
    logic [31:0] xfer_bytes;
    logic        xfer_write;
    logic [87:0] xfer_tag;
    logic        xfer_done = 1'b0;
    logic        busy, chain_done, irq;

    int errors = 0;
    int checks = 0;

    logic [63:0] mem [0:255];
    logic [63:0] rd_log [0:31];
    logic [63:0] c_addr [0:7];
    logic [31:0] c_bytes [0:7];
    logic        c_wr [0:7];
    logic [87:0] c_tag [0:7];
    int n_rd = 0, n_cmd = 0, n_irq = 0;
    int eng_lat = 3, eng_cnt = 0;
    bit cancel_at_done = 0;
    int viol_r3 = 0, viol_r6 = 0;
    logic prev_req = 1'b0;
    logic [63:0] prev_addr = '0;

    always #5 clk = ~clk;

    dma_chain_walker u_dma_chain_walker (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .chain_addr_i(chain_addr),
        .cancel_i(cancel_i), .rd_req_o(rd_req), .rd_addr_o(rd_addr),
        .rd_valid_i(rd_valid), .rd_data_i(rd_data), .xfer_valid_o(xfer_valid),
        .xfer_addr_o(xfer_addr), .xfer_bytes_o(xfer_bytes), .xfer_write_o(xfer_write),
        .xfer_tag_o(xfer_tag), .xfer_done_i(xfer_done), .busy_o(busy),
        .chain_done_o(chain_done), .irq_o(irq)
    );

    // Models and monitors, all at the falling edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_req && !rd_valid && (!rd_req || rd_addr != prev_addr)) viol_r3++;
            if (rd_req && xfer_valid) viol_r6++;
        end
        prev_req  = rd_req;
        prev_addr = rd_addr;
        if (irq) n_irq++;
        if (rd_valid) rd_valid = 1'b0;
        else if (rd_req) begin
            rd_valid = 1'b1;
            rd_data  = mem[rd_addr[10:3]];
            if (n_rd < 32) rd_log[n_rd] = rd_addr;
            n_rd++;
        end
        if (xfer_done) begin
            xfer_done = 1'b0;
            if (cancel_at_done) cancel_i = 1'b0;
        end else if (xfer_valid) begin
            if (eng_cnt >= eng_lat) begin
                xfer_done = 1'b1;
                eng_cnt = 0;
                if (n_cmd < 8) begin
                    c_addr[n_cmd] = xfer_addr; c_bytes[n_cmd] = xfer_bytes;
                    c_wr[n_cmd] = xfer_write;  c_tag[n_cmd] = xfer_tag;
                end
                n_cmd++;
                if (cancel_at_done) cancel_i = 1'b1;
            end else eng_cnt++;
        end
    end

    task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic put_desc(input logic [63:0] base, input logic [63:0] a, input logic [63:0] usr,
                            input logic [31:0] bytes, input logic [23:0] u24,
                            input logic [7:0] flg, input logic [63:0] nxt);
        mem[base[10:3]]     = a;
        mem[base[10:3] + 1] = usr;
        mem[base[10:3] + 2] = {bytes, u24, flg};
        mem[base[10:3] + 3] = nxt;
    endtask

    task automatic clear_logs();
        n_rd = 0; n_cmd = 0; n_irq = 0; eng_cnt = 0;
    endtask

    task automatic pulse_start(input logic [63:0] a);
        @(negedge clk); chain_addr = a; start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
    endtask

    task automatic pulse_cancel();
        @(negedge clk); cancel_i = 1'b1;
        @(negedge clk); cancel_i = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 3000 && busy; i++) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic wait_cmd();
        for (int i = 0; i < 3000 && !xfer_valid; i++) @(negedge clk);
    endtask

    task automatic build_chain3();
        put_desc(64'h100, 64'hAAAA_0000_1000_0000, 64'h1111_2222_3333_4444, 32'h0000_0400, 24'hABCDEF, 8'h01, 64'h24B);
        put_desc(64'h240, 64'hBBBB_0000_2000_0008, 64'h5555_6666_7777_8888, 32'h0000_0010, 24'h123456, 8'h00, 64'h3BF);
        put_desc(64'h3A0, 64'hCCCC_0000_3000_0040, 64'h9999_AAAA_BBBB_CCCC, 32'h0001_0000, 24'h0F0F0F, 8'h06, 64'h0);
    endtask

    task automatic t_reset();
        check("R1 rd_req", rd_req, 0);
        check("R1 xfer_valid", xfer_valid, 0);
        check("R1 busy", busy, 0);
        check("R1 chain_done", chain_done, 0);
        check("R1 irq", irq, 0);
    endtask

    task automatic t_chain3();
        logic [63:0] bases [0:2];
        bases[0] = 64'h100; bases[1] = 64'h240; bases[2] = 64'h3A0;
        build_chain3(); clear_logs(); eng_lat = 3;
        pulse_start(64'h105);
        wait_idle();
        check("R2 R6 read count", n_rd, 12);
        for (int d = 0; d < 3; d++)
            for (int w = 0; w < 4; w++)
                check("R2 R6 read address", rd_log[d*4+w], bases[d] + 64'(w*8));
        check("R4 command count", n_cmd, 3);
        check("R4 addr0", c_addr[0], 64'hAAAA_0000_1000_0000);
        check("R4 bytes0", c_bytes[0], 32'h400);
        check("R4 write0", c_wr[0], 1);
        check("R4 write1", c_wr[1], 0);
        check("R4 bytes2", c_bytes[2], 32'h0001_0000);
        check("R5 tag0", c_tag[0], {64'h1111_2222_3333_4444, 24'hABCDEF});
        check("R5 tag1", c_tag[1], {64'h5555_6666_7777_8888, 24'h123456});
        check("R5 tag2", c_tag[2], {64'h9999_AAAA_BBBB_CCCC, 24'h0F0F0F});
        check("R7 chain_done", chain_done, 1);
        check("R7 busy", busy, 0);
        check("R8 irq pulses", n_irq, 1);
    endtask

    task automatic t_single_busy_start();
        put_desc(64'h400, 64'hDDDD_0000_0000_0100, 64'h0123_4567_89AB_CDEF, 32'h20, 24'h000001, 8'h02, 64'h100);
        clear_logs(); eng_lat = 20;
        pulse_start(64'h400);
        check("R7 chain_done cleared by start", chain_done, 0);
        wait_cmd();
        pulse_start(64'h100);
        wait_idle();
        check("R11 reads with start while busy", n_rd, 4);
        check("R11 commands with start while busy", n_cmd, 1);
        check("R4 single addr", c_addr[0], 64'hDDDD_0000_0000_0100);
        check("R8 no irq when bit clear", n_irq, 0);
        check("R7 single chain_done", chain_done, 1);
        eng_lat = 3;
    endtask

    task automatic t_cancel_xfer();
        build_chain3(); clear_logs(); eng_lat = 10;
        pulse_start(64'h100);
        wait_cmd();
        pulse_cancel();
        wait_idle();
        check("R9 cancel in transfer: commands", n_cmd, 1);
        check("R9 cancel in transfer: reads", n_rd, 4);
        check("R9 cancel in transfer: chain_done", chain_done, 0);
        check("R9 cancel in transfer: busy", busy, 0);
        check("R9 cancel in transfer: irq", n_irq, 0);
        eng_lat = 3;
    endtask

    task automatic t_cancel_fetch();
        build_chain3(); clear_logs();
        pulse_start(64'h100);
        pulse_cancel();
        wait_idle();
        check("R9 cancel in fetch: commands", n_cmd, 0);
        check("R9 cancel in fetch: reads", n_rd, 4);
        check("R9 cancel in fetch: busy", busy, 0);
        check("R9 cancel in fetch: chain_done", chain_done, 0);
    endtask

    task automatic t_cancel_on_last();
        put_desc(64'h400, 64'hDDDD_0000_0000_0100, 64'h0123_4567_89AB_CDEF, 32'h20, 24'h000001, 8'h06, 64'h100);
        clear_logs(); cancel_at_done = 1;
        pulse_start(64'h400);
        wait_idle();
        cancel_at_done = 0; cancel_i = 1'b0;
        check("R10 commands", n_cmd, 1);
        check("R10 chain_done wins over cancel", chain_done, 1);
        check("R10 busy", busy, 0);
        check("R10 irq", n_irq, 1);
    endtask

    task automatic t_idle_cancel();
        pulse_cancel();
        build_chain3(); clear_logs();
        pulse_start(64'h100);
        wait_idle();
        check("R11 idle cancel: commands", n_cmd, 3);
        check("R11 idle cancel: chain_done", chain_done, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = '0;
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_chain3();
        t_single_busy_start();
        t_cancel_xfer();
        t_cancel_fetch();
        t_cancel_on_last();
        t_idle_cancel();
        check("R3 read request held until data", viol_r3, 0);
        check("R6 no read while command valid", viol_r6, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule